// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that watches the SCL and SDA lines and gives a bus master access to an internal bank of sixteen 8-bit registers. SCL and SDA are first passed through two synchronising flops to the system clock. Start and stop conditions are then detected on the synchronised samples. SDA is open-drain: the block never drives it high, and it only asserts `sda_oe` to pull the line low.

A write transaction has four parts in order: a start, the 7-bit target address with the direction bit at 0, a pointer byte that selects the first register, and any number of data bytes. Each data byte goes into consecutive registers. A read is usually a pointer write followed by a repeated start and the address with the direction bit at 1. The target then returns consecutive registers for as long as the master acknowledges each byte.

Top module: `i2c_reg_target`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After reset, after a start and after a stop, `sda_oe` is 0.
- R2: If the 7 bits received after a start (MSB first) equal `DEV_ADDR`, the target pulls SDA low during the ninth SCL pulse, whatever the direction bit (eighth bit, 0 = write, 1 = read).
- R3: If the address does not match, `sda_oe` stays 0 and every later byte is ignored, with no acknowledge and no register change, until the next start.
- R4: In a write, the first byte after the address is the pointer and is acknowledged. Bits 3:0 select the register and bits 7:4 are ignored.
- R5: Each write data byte after the pointer is acknowledged, is stored in the register the pointer selects, and then advances the pointer by one.
- R6: The pointer wraps from register 15 to register 0, for both writes and reads.
- R7: The number of data bytes is not limited. A stop or a repeated start ends the write, and registers past the last byte sent keep their values.
- R8: In a read, the target sends the selected register MSB first. It changes SDA only while SCL is low and advances the pointer after each byte.
- R9: An acknowledge from the master (SDA low on the ninth pulse) makes the target send the next register. A not-acknowledge makes it release SDA and send nothing until the next start or stop.
- R10: A read uses the pointer left by the last pointer byte, data write or read byte, including across a repeated start or a stop.
- R11: All registers reset to 0x00 and the pointer resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench acts as the bus master and drives four kinds of transaction. Writes to the matching address show whether data lands in the right registers and whether the pointer wraps. Traffic to a wrong address shows whether the target stays silent and leaves the bank untouched. Pointer-then-read sequences with repeated starts, and bare reads after a stop, tell a pointer that is reloaded apart from one that carries over. Multi-byte reads that end in a not-acknowledge, followed by extra clocked slots, show whether the target really lets go of SDA after the last byte.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } tgt_state_t;

  // Upper seven bits of the received address byte hold the target address
  function automatic logic byte_addr_hit(input logic [7:0] rx, input logic [6:0] own);
    return rx[7:1] == own;
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_bank.sv
module i2c_tgt_bank #(
  parameter int PTR_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NREG = 1 << PTR_W;

  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         PTR_W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = '1;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  tgt_state_t state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, txsh, rd_data;
  logic [PTR_W-1:0]  ptr;
  logic rw, ack_drv, tx_drv, mack;
  logic byte_done, ack_done, wr_en;

  i2c_tgt_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign byte_done = scl_fall && (cnt == CNT_BYTE);
  assign ack_done  = scl_fall && (cnt == CNT_ACK);
  assign wr_en     = (state == ST_WDATA) && byte_done && !start_evt && !stop_evt;

  i2c_tgt_bank #(.PTR_W(PTR_W), .DATA_W(BYTE_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr), .wr_data(shreg),
    .rd_idx(ptr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      txsh    <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      ack_drv <= 1'b0;
      tx_drv  <= 1'b0;
      mack    <= 1'b0;
    end else if (start_evt || stop_evt) begin
      state   <= start_evt ? ST_ADDR : ST_IDLE;
      cnt     <= '0;
      ack_drv <= 1'b0;
      tx_drv  <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            if (cnt < CNT_BYTE) shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt <= cnt + CNT_W'(1);
          end else if (byte_done) begin
            if (state == ST_ADDR) begin
              if (byte_addr_hit(shreg, DEV_ADDR)) begin
                ack_drv <= 1'b1;
                rw      <= shreg[0];
              end else begin
                state <= ST_WAIT;
              end
            end else begin
              ack_drv <= 1'b1;
              ptr     <= (state == ST_PTR) ? shreg[PTR_W-1:0] : ptr_step(ptr);
            end
          end else if (ack_done) begin
            ack_drv <= 1'b0;
            cnt     <= '0;
            if (state == ST_ADDR) begin
              if (rw) begin
                state  <= ST_RDATA;
                txsh   <= rd_data;
                tx_drv <= ~rd_data[BYTE_W-1];
              end else begin
                state <= ST_PTR;
              end
            end else begin
              state <= ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            if (cnt == CNT_BYTE) mack <= ~sda_s;
            cnt <= cnt + CNT_W'(1);
          end else if (scl_fall) begin
            if (cnt != '0 && cnt < CNT_BYTE) begin
              txsh   <= {txsh[BYTE_W-2:0], 1'b0};
              tx_drv <= ~txsh[BYTE_W-2];
            end else if (cnt == CNT_BYTE) begin
              tx_drv <= 1'b0;
              ptr    <= ptr_step(ptr);
            end else if (cnt == CNT_ACK) begin
              cnt <= '0;
              if (mack) begin
                txsh   <= rd_data;
                tx_drv <= ~rd_data[BYTE_W-1];
              end else begin
                state <= ST_WAIT;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = ack_drv | tx_drv;
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
  import i2c_tgt_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             sda_oe,
  input logic             ack_drv,
  input logic             tx_drv,
  input logic             wr_en,
  input logic [PTR_W-1:0] ptr,
  input tgt_state_t       state
);
  localparam logic [PTR_W-1:0] PTR_LAST = '1;

  assert_release_on_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  assert_release_on_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  assert_silent_when_ignoring_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sda_oe);

  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == PTR_LAST) |=> (ptr == '0));

  assert_sda_moves_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_single_driver_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_drv, tx_drv}));
endmodule

bind i2c_reg_target i2c_tgt_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_oe(sda_oe), .ack_drv(ack_drv), .tx_drv(tx_drv),
  .wr_en(wr_en), .ptr(ptr), .state(state)
);

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic sda_bus;

  always #10 clk = ~clk;
  assign sda_bus = !(m_low || sda_oe);

  i2c_reg_target #(.DEV_ADDR(ADDR)) i_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mregs [16];
  int mptr = 0;

  task automatic check(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // One SCL pulse; sda_oe compared with the model on every clock of the high phase
  task automatic slot(input logic drv_low, input logic eoe, input string tag, output logic seen);
    repeat (Q) @(negedge clk);
    m_low = drv_low;
    repeat (Q) @(negedge clk);
    scl = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < Q; k++) begin
      @(negedge clk);
      check({tag, " sda_oe"}, int'(sda_oe), int'(eoe));
    end
    seen = sda_bus;
    @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic do_start();
    m_low = 1'b0;
    repeat (Q) @(negedge clk);
    scl = 1'b1;
    repeat (2 * Q) @(negedge clk);
    m_low = 1'b1;
    repeat (2 * Q) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic do_stop();
    m_low = 1'b1;
    repeat (Q) @(negedge clk);
    scl = 1'b1;
    repeat (2 * Q) @(negedge clk);
    m_low = 1'b0;
    repeat (2 * Q) @(negedge clk);
    check("R1 released after stop", int'(sda_oe), 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic s;
    for (int i = 7; i >= 0; i--) slot(~b[i], 1'b0, tag, s);
    slot(1'b0, exp_ack, tag, s);
    check({tag, " ack"}, int'(!s), int'(exp_ack));
  endtask

  task automatic recv_byte(input logic [7:0] expb, input logic mack, input string tag);
    logic s;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      slot(1'b0, ~expb[i], tag, s);
      got[i] = s;
    end
    slot(mack, 1'b0, tag, s);
    check({tag, " data"}, int'(got), int'(expb));
  endtask

  // Model: write through the bank from a pointer byte
  task automatic wr_txn(input logic [7:0] pbyte, input logic [7:0] d [$], input string tag);
    do_start();
    send_byte({ADDR, 1'b0}, 1'b1, {tag, " R2 addr"});
    send_byte(pbyte, 1'b1, {tag, " R4 ptr"});
    mptr = int'(pbyte[3:0]);
    foreach (d[i]) begin
      send_byte(d[i], 1'b1, {tag, " R5 data"});
      mregs[mptr] = d[i];
      mptr = (mptr + 1) % 16;
    end
  endtask

  // Model: read n bytes from the current pointer, NACK on the last
  task automatic rd_bytes(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      recv_byte(mregs[mptr], i != n - 1, tag);
      mptr = (mptr + 1) % 16;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] q [$];
    logic s;
    for (int i = 0; i < 16; i++) mregs[i] = 8'h00;
    repeat (4) @(negedge clk);
    check("R1 reset sda_oe", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset contents read from pointer 0
    do_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R2 read addr");
    rd_bytes(2, "R11 reset value");
    do_stop();

    // R5: single byte write
    q = '{8'hA5};
    wr_txn(8'h03, q, "R5 single");
    do_stop();

    // R6 / R7: burst across the wrap point
    q = '{8'h11, 8'h22, 8'h33, 8'h44};
    wr_txn(8'h0E, q, "R6 wrap write");
    do_stop();

    // R3: foreign address, following bytes ignored
    do_start();
    send_byte({7'h2B, 1'b0}, 1'b0, "R3 foreign addr");
    send_byte(8'h05, 1'b0, "R3 ignored ptr");
    send_byte(8'hEE, 1'b0, "R3 ignored data");
    do_stop();

    // R4 / R10 / R8 / R6: pointer byte with high bits set, repeated start, long read
    q = {};
    wr_txn(8'hFE, q, "R4 high bits");
    do_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R10 restart addr");
    rd_bytes(8, "R8 burst read");
    // R9: after NACK no further data
    for (int i = 0; i < 9; i++) slot(1'b0, 1'b0, "R9 after nack", s);
    do_stop();

    // R10: pointer-only write, then reads across a stop
    q = '{8'h5A, 8'h6B, 8'hC7};
    wr_txn(8'h06, q, "R7 fill");
    do_stop();
    q = {};
    wr_txn(8'h06, q, "R4 ptr only");
    do_stop();
    do_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R10 read");
    rd_bytes(2, "R10 from ptr");
    do_stop();
    do_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R10 resume");
    rd_bytes(1, "R10 carried ptr");
    do_stop();

    // R3: foreign address in read direction stays silent
    do_start();
    send_byte({7'h55, 1'b1}, 1'b0, "R3 foreign read");
    for (int i = 0; i < 9; i++) slot(1'b0, 1'b0, "R3 silent", s);
    do_stop();

    // R7: write ended by repeated start, then read continues at next register
    q = '{8'h9D};
    wr_txn(8'h0A, q, "R7 restart write");
    do_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R7 restart read");
    rd_bytes(1, "R7 next reg");
    do_stop();
    do_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R7 ptr back");
    send_byte(8'h0A, 1'b1, "R7 ptr back");
    mptr = 10;
    do_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R7 check");
    rd_bytes(2, "R7 kept");
    do_stop();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule